// File: doc/BRIEF.md
# Triggered Pattern Output Latch

This block holds a staged byte of pattern data and moves it into an output register on a timer event. The output register drives eight pins. A processor loads the staged byte through a small byte-wide register port. When a compare-match pulse arrives, the staged bits move to the pins in one clock, without any further processor action. This gives waveforms with cycle-exact timing while software prepares the next value.

The eight pins form two four-bit groups. Group 1 is bits 7..4 and group 0 is bits 3..0. In shared mode both groups follow trigger 0, and the staged byte sits at one address as a whole byte. In split mode each group follows its own trigger, and each group's nibble sits at its own address. A per-bit enable mask can hold any pin at its present level. A hardware-standby input clears the block. A software-standby input freezes it.

Top module: `pattern_latch`

## Requirements
- R1: After reset the staged byte and the pin register are both 0x00.
- R2: In shared mode (`share_mode`=1), offset 5 is the full staged byte. A write stores all 8 bits, and a read returns them.
- R3: In shared mode, offset 7 always reads 0xFF, and writes to it change nothing.
- R4: In split mode (`share_mode`=0), offset 5 bits 7..4 hold the group 1 nibble and offset 7 bits 3..0 hold the group 0 nibble. The other half of each byte reads as 1111 and ignores writes.
- R5: In shared mode, a `trig0` pulse copies all enabled staged bits to the pins at the next clock edge. `trig1` has no effect.
- R6: In split mode, `trig1` copies only bits 7..4 and `trig0` copies only bits 3..0. The pins of the other group keep their value.
- R7: A pin whose `out_en` bit is 0 keeps its value when a trigger occurs.
- R8: When a write and a trigger fall in the same cycle, the pins take the old staged value, and the new value is stored for later.
- R9: `hw_stby` clears the staged byte and the pin register to 0x00 at the next clock edge. It takes priority over everything else.
- R10: While `sw_stby` is high (and `hw_stby` is low), the staged byte and the pins hold their values, and writes and triggers are ignored.
- R11: Offsets other than 5 and 7 read 0xFF and ignore writes in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby, clears the staged byte and the pins |
| sw_stby | input | 1 | Software standby, freezes all state |
| share_mode | input | 1 | 1: both groups follow trig0; 0: each group has its own trigger |
| bus_addr | input | 3 | Register offset within the block window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| trig0 | input | 1 | Single-cycle trigger for group 0 (both groups in shared mode) |
| trig1 | input | 1 | Single-cycle trigger for group 1 in split mode |
| out_en | input | 8 | Per-pin transfer enable |
| pins | output | 8 | Output pattern register |

## Verification
The bench sweeps every staged byte in shared mode and every nibble pair in split mode. Each sweep uses a changing enable mask and compares the pins against an arithmetic model. A decode that ignored the mode would let a split-mode trigger move the other group's pins, or would show staged bits in the reserved halves. A wrong trigger order would send the new value, rather than the old one, to the pins on a same-cycle write and trigger. The bench also pulses software standby and hardware standby after loading data. A design that cleared on the wrong input would either lose the staged byte while frozen or keep stale data after a clear.

// File: rtl/pattern_latch_pkg.sv
package pattern_latch_pkg;
    localparam int GRP_W  = 4;
    localparam int N_GRP  = 2;
    localparam int DATA_W = GRP_W * N_GRP;
    localparam int ADDR_W = 3;

    typedef struct packed {
        logic [DATA_W-1:0] staged;
        logic [DATA_W-1:0] pins;
    } latch_state_t;
endpackage

// File: rtl/pattern_latch_regif.sv
module pattern_latch_regif
    import pattern_latch_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OFF_MAIN = 3'd5,
    parameter logic [ADDR_W-1:0] OFF_AUX  = 3'd7
) (
    input  logic              share_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] staged_q,
    output logic [DATA_W-1:0] wr_mask,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [GRP_W-1:0] ONES_G = '1;
    localparam logic [GRP_W-1:0] ZERO_G = '0;

    logic [DATA_W-1:0] vis_mask;

    always_comb begin
        // which staged bits are visible at this offset
        vis_mask = '0;
        if (addr == OFF_MAIN) begin
            vis_mask = share_mode ? '1 : {ONES_G, ZERO_G};
        end else if (addr == OFF_AUX && !share_mode) begin
            vis_mask = {ZERO_G, ONES_G};
        end
        rdata   = (staged_q & vis_mask) | ~vis_mask;
        wr_mask = wr ? vis_mask : '0;
    end
endmodule

// File: rtl/pattern_latch_xfer.sv
module pattern_latch_xfer
    import pattern_latch_pkg::*;
(
    input  logic              share_mode,
    input  logic [N_GRP-1:0]  trig,
    input  logic [DATA_W-1:0] out_en,
    output logic [DATA_W-1:0] xfer_mask
);
    logic [N_GRP-1:0] fire;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign fire[g] = share_mode ? trig[0] : trig[g];
        assign xfer_mask[g*GRP_W +: GRP_W] = {GRP_W{fire[g]}} & out_en[g*GRP_W +: GRP_W];
    end
endmodule

// File: rtl/pattern_latch.sv
module pattern_latch
    import pattern_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              share_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              trig0,
    input  logic              trig1,
    input  logic [DATA_W-1:0] out_en,
    output logic [DATA_W-1:0] pins
);
    latch_state_t      st_d, st_q;
    logic [DATA_W-1:0] wr_mask;
    logic [DATA_W-1:0] xfer_mask;

    pattern_latch_regif u_regif (
        .share_mode (share_mode),
        .addr       (bus_addr),
        .wr         (bus_wr),
        .staged_q   (st_q.staged),
        .wr_mask    (wr_mask),
        .rdata      (bus_rdata)
    );

    pattern_latch_xfer u_xfer (
        .share_mode (share_mode),
        .trig       ({trig1, trig0}),
        .out_en     (out_en),
        .xfer_mask  (xfer_mask)
    );

    always_comb begin
        st_d = st_q;
        if (hw_stby) begin
            st_d = '0;
        end else if (!sw_stby) begin
            // transfer uses the current staged value, before any write lands
            st_d.pins   = (st_q.pins & ~xfer_mask) | (st_q.staged & xfer_mask);
            st_d.staged = (st_q.staged & ~wr_mask) | (bus_wdata & wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pins = st_q.pins;
endmodule

// File: rtl/pattern_latch_chk.sv
module pattern_latch_chk
    import pattern_latch_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hw_stby,
    input logic              sw_stby,
    input logic              share_mode,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              trig0,
    input logic              trig1,
    input logic [DATA_W-1:0] out_en,
    input logic [DATA_W-1:0] pins
);
    p_hwstby_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (pins == '0));

    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> $stable(pins));

    p_no_trig_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig0 && !trig1 && !hw_stby) |=> $stable(pins));

    p_masked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_stby |=> (((pins ^ $past(pins)) & ~$past(out_en)) == '0));

    p_rsvd_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (share_mode && bus_addr == 3'd7) |-> (bus_rdata == 8'hFF));

    p_split_lo_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!share_mode && bus_addr == 3'd5) |-> (bus_rdata[3:0] == 4'hF));
endmodule

bind pattern_latch pattern_latch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_stby    (hw_stby),
    .sw_stby    (sw_stby),
    .share_mode (share_mode),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .trig0      (trig0),
    .trig1      (trig1),
    .out_en     (out_en),
    .pins       (pins)
);

// File: tb/tb_pattern_latch.sv
module tb_pattern_latch;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       hw_stby = 0, sw_stby = 0, share_mode = 1;
    logic [2:0] bus_addr = 0;
    logic       bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       trig0 = 0, trig1 = 0;
    logic [7:0] out_en = 8'hFF;
    logic [7:0] pins;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] exp_pins;

    always #2.5 clk = ~clk;

    pattern_latch dut (.*);

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1; step(); bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; #0.5; chk(bus_rdata, exp, tag);
    endtask

    task automatic fire(input logic t0, input logic t1);
        trig0 = t0; trig1 = t1; step(); trig0 = 0; trig1 = 0;
    endtask

    initial begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1; step();
        // R1 reset state
        chk(pins, 8'h00, "R1 pins");
        rd(3'd5, 8'h00, "R1 staged");
        exp_pins = 8'h00;

        // R2 R5 R7: shared sweep over every byte value
        share_mode = 1;
        for (int d = 0; d < 256; d++) begin
            logic [7:0] oe;
            oe = 8'(d * 37) ^ 8'hA5;
            wr(3'd5, 8'(d));
            rd(3'd5, 8'(d), "R2 readback");
            out_en = oe;
            fire(0, 1);
            chk(pins, exp_pins, "R5 trig1 ignored in shared");
            fire(1, 0);
            exp_pins = (exp_pins & ~oe) | (8'(d) & oe);
            chk(pins, exp_pins, "R5 R7 shared transfer");
        end

        // R3 reserved companion
        wr(3'd7, 8'h00);
        rd(3'd7, 8'hFF, "R3 reserved read");
        rd(3'd5, 8'hFF, "R3 write had no effect");

        // R11 unmapped offsets
        for (int a = 0; a < 8; a++) begin
            if (a != 5 && a != 7) begin
                wr(3'(a), 8'h3C);
                rd(3'(a), 8'hFF, "R11 unmapped read");
            end
        end
        rd(3'd5, 8'hFF, "R11 staged untouched");

        // R4 R6: split sweep over all nibble pairs
        share_mode = 0;
        out_en = 8'hFF;
        for (int h = 0; h < 16; h++) begin
            for (int l = 0; l < 16; l++) begin
                logic [7:0] oe;
                oe = 8'(h * 16 + l) ^ 8'h3C;
                wr(3'd5, {4'(h), 4'(15 - l)});
                wr(3'd7, {4'(l), 4'(l)});
                rd(3'd5, {4'(h), 4'hF}, "R4 offset5 map");
                rd(3'd7, {4'hF, 4'(l)}, "R4 offset7 map");
                out_en = oe;
                fire(0, 1);
                exp_pins[7:4] = (exp_pins[7:4] & ~oe[7:4]) | (4'(h) & oe[7:4]);
                chk(pins, exp_pins, "R6 trig1 upper only");
                fire(1, 0);
                exp_pins[3:0] = (exp_pins[3:0] & ~oe[3:0]) | (4'(l) & oe[3:0]);
                chk(pins, exp_pins, "R6 trig0 lower only");
            end
        end

        // R8 write and trigger together (shared)
        share_mode = 1; out_en = 8'hFF;
        wr(3'd5, 8'h81);
        bus_addr = 3'd5; bus_wdata = 8'h7E; bus_wr = 1; trig0 = 1;
        step(); bus_wr = 0; trig0 = 0;
        chk(pins, 8'h81, "R8 old value transferred");
        rd(3'd5, 8'h7E, "R8 new value stored");
        exp_pins = 8'h81;

        // R10 software standby freezes
        sw_stby = 1;
        wr(3'd5, 8'h11);
        fire(1, 1);
        chk(pins, exp_pins, "R10 pins held");
        rd(3'd5, 8'h7E, "R10 staged held");
        sw_stby = 0;
        fire(1, 0);
        chk(pins, 8'h7E, "R10 resumes after standby");

        // R9 hardware standby clears
        hw_stby = 1; step(); hw_stby = 0;
        chk(pins, 8'h00, "R9 pins cleared");
        rd(3'd5, 8'h00, "R9 staged cleared");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule